// File: doc/BRIEF.md
# Time-Shared Wide Unsigned Multiplier

This block forms the full-width unsigned product of two operands, each twice the width of a single narrow multiplier, using one half-width multiplier over several cycles. Each operand is cut into an upper and a lower half. The four half-by-half products are formed one per cycle and added into a double-width accumulator. The two mixed terms carry a weight of one half-width shift and the upper-by-upper term carries a weight of two half-width shifts. With the default half width of 16, two 32-bit operands give a 64-bit product, and only 16x16 multiplication is used.

A caller presents both operands with a one-cycle start pulse. The block raises busy and runs the four partial products in a fixed order: low-by-low, low-by-high, high-by-low, high-by-high. One more cycle folds the last term into the sum. It then pulses done for one cycle. The result stays on its output until the next accepted start. A start that arrives while the block is busy is dropped. Signed operands, saturation and overlap of successive operations are not part of this block.

Top module: `wide_mul`

## Requirements
- R1: While reset is high and in the cycle after it falls with no start, busy_o is 0, done_o is 0 and result_o is 0.
- R2: For any unsigned a_i and b_i, result_o equals a_i*b_i at full double width (64 bits at the default) in the cycle done_o is high.
- R3: If start_i is sampled high at clock edge k while busy_o is low, done_o is high for exactly one cycle, after edge k+5, and low after edges k+1 to k+4.
- R4: busy_o is high after edges k+1 to k+4 and low in the cycle done_o is high.
- R5: A start_i pulse sampled while busy_o is high is ignored: the operands presented with it do not change the result of the running operation.
- R6: After done_o, result_o and done_o stay unchanged for as long as no start is accepted.
- R7: A start_i raised in the cycle done_o is high is accepted, so operations can follow each other with no idle cycle.
- R8: The carries out of the two mixed terms are kept. For a_i = b_i = 0xFFFFFFFF the result is 0xFFFFFFFE00000001, and every pairing of 0, 0xFFFFFFFF, 0x0000FFFF and 0xFFFF0000 is exact.
- R9: The block is correct for any HALF_W. At HALF_W = 3, every pair of 6-bit operands gives the exact 12-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request; operands are sampled with it |
| a_i | input | 2*HALF_W | Multiplicand, unsigned |
| b_i | input | 2*HALF_W | Multiplier, unsigned |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | 4*HALF_W | Product, held until the next accepted start |

## Verification
Two events can fall in the same cycle: a new start request, and either the final accumulate or the completion of the previous operation. The bench raises a start in the cycle after acceptance, while the block is busy, with different operands. It passes if the finished product still matches the first pair. It also raises a start in the very cycle done is high. That case passes if the new operation is taken with no idle cycle and still returns the exact product after the fixed latency. An exhaustive sweep at a 3-bit half width and a sweep of the half-width corner values at full width check the sums, the carries and the cycle timing against arithmetic products computed in the bench.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LAST = 2'd2
  } wm_state_e;

  localparam int STEPS   = 4;
  localparam int STEP_W  = $clog2(STEPS);
  // cycles from accepting edge to the edge that raises done
  localparam int LATENCY = STEPS + 1;
endpackage

// File: rtl/wm_seq.sv
module wm_seq
  import wmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mul_en_o,
  output logic [STEP_W-1:0] step_o
);
  wm_state_e         state_q;
  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            busy_o  <= 1'b1;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == STEP_W'(STEPS - 1)) state_q <= ST_LAST;
        end
        ST_LAST: begin
          state_q <= ST_IDLE;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mul_en_o = (state_q == ST_RUN);
  assign step_o   = cnt_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R4
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: rtl/wm_narrow_mul.sv
module wm_narrow_mul #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [HALF_W-1:0]   a_i,
  input  logic [HALF_W-1:0]   b_i,
  input  logic [1:0]          sh_i,
  output logic [2*HALF_W-1:0] p_o,
  output logic [1:0]          sh_o,
  output logic                vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      sh_o  <= 2'd0;
      p_o   <= '0;
    end else begin
      vld_o <= en_i;
      if (en_i) begin
        p_o  <= a_i * b_i;
        sh_o <= sh_i;
      end
    end
  end
endmodule

// File: rtl/wm_accum.sv
module wm_accum #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [2*HALF_W-1:0] pp_i,
  input  logic [1:0]          sh_i,
  output logic [4*HALF_W-1:0] acc_o
);
  localparam int PW = 4 * HALF_W;

  logic [PW-1:0] ext;
  logic [PW-1:0] shifted;
  logic [PW:0]   sum;

  assign ext = {{(2*HALF_W){1'b0}}, pp_i};

  always_comb begin
    case (sh_i)
      2'd0:    shifted = ext;
      2'd1:    shifted = ext << HALF_W;
      default: shifted = ext << (2 * HALF_W);
    endcase
  end

  assign sum = {1'b0, acc_o} + {1'b0, shifted};

  always_ff @(posedge clk) begin
    if (rst)        acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (add_i) acc_o <= sum[PW-1:0];
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    add_i |-> !sum[PW]);
endmodule

// File: rtl/wide_mul.sv
module wide_mul
  import wmul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [4*HALF_W-1:0] result_o
);
  localparam int OW = 2 * HALF_W;

  logic              accept;
  logic [OW-1:0]     a_q, b_q;
  logic              mul_en;
  logic [STEP_W-1:0] step;
  logic [HALF_W-1:0] a_half, b_half;
  logic [1:0]        sh;
  logic [OW-1:0]     pp;
  logic [1:0]        pp_sh;
  logic              pp_vld;

  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // step bit 1 picks the upper half of a, bit 0 the upper half of b
  assign a_half = step[1] ? a_q[OW-1:HALF_W] : a_q[HALF_W-1:0];
  assign b_half = step[0] ? b_q[OW-1:HALF_W] : b_q[HALF_W-1:0];
  assign sh     = {step[1] & step[0], step[1] ^ step[0]};

  wm_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .mul_en_o (mul_en),
    .step_o   (step)
  );

  wm_narrow_mul #(.HALF_W(HALF_W)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .en_i  (mul_en),
    .a_i   (a_half),
    .b_i   (b_half),
    .sh_i  (sh),
    .p_o   (pp),
    .sh_o  (pp_sh),
    .vld_o (pp_vld)
  );

  wm_accum #(.HALF_W(HALF_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (accept),
    .add_i (pp_vld),
    .pp_i  (pp),
    .sh_i  (pp_sh),
    .acc_o (result_o)
  );

  // latency watch for the assertion below
  logic [3:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (accept) lat_q <= 4'd1;
    else if (busy_o) lat_q <= lat_q + 4'd1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == 4'(LATENCY + 1)));
  // R5
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q)));
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/wide_mul_bench.sv
`timescale 1ns/1ps
module wide_mul_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [63:0] res;

  logic        s_start = 1'b0;
  logic [5:0]  s_a = '0, s_b = '0;
  logic        s_busy, s_done;
  logic [11:0] s_res;

  int n_chk = 0;
  int n_bad = 0;

  wide_mul #(.HALF_W(16)) u_wide_mul (
    .clk(clk), .rst(rst), .start_i(start), .a_i(opa), .b_i(opb),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  wide_mul #(.HALF_W(3)) u_wide_mul_small (
    .clk(clk), .rst(rst), .start_i(s_start), .a_i(s_a), .b_i(s_b),
    .busy_o(s_busy), .done_o(s_done), .result_o(s_res)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after done
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input bit inject, input string tag);
    logic [63:0] exp;
    exp = {32'b0, a} * {32'b0, b};
    start = 1'b1; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R4 busy after accept", {63'b0, busy}, 64'd1);
    check(done === 1'b0, "R3 no early done", {63'b0, done}, 64'd0);
    for (int k = 1; k <= 4; k++) begin
      if (inject && k == 1) begin
        start = 1'b1; opa = ~a; opb = b ^ 32'h5a5a_a5a5;
      end
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b0, "R3 done low while running", {63'b0, done}, 64'd0);
      check(busy === 1'b1, "R4 busy while running", {63'b0, busy}, 64'd1);
    end
    @(negedge clk);
    check(done === 1'b1, "R3 done after five edges", {63'b0, done}, 64'd1);
    check(busy === 1'b0, "R4 busy low with done", {63'b0, busy}, 64'd0);
    check(res === exp, tag, res, exp);
  endtask

  task automatic run_small(input logic [5:0] a, input logic [5:0] b);
    logic [11:0] exp;
    exp = {6'b0, a} * {6'b0, b};
    s_start = 1'b1; s_a = a; s_b = b;
    @(negedge clk);
    s_start = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk);
    check(s_done === 1'b1 && s_res === exp, "R9 small width product",
          {51'b0, s_done, s_res}, {51'b0, 1'b1, exp});
  endtask

  logic [31:0] corners [4];

  initial begin
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h0000_FFFF;
    corners[3] = 32'hFFFF_0000;

    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && res === 64'd0, "R1 in reset",
          {busy, done, res[61:0]}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && res === 64'd0, "R1 after reset",
          {busy, done, res[61:0]}, 64'd0);

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 all ones");
    check(res === 64'hFFFF_FFFE_0000_0001, "R8 all ones literal", res,
          64'hFFFF_FFFE_0000_0001);

    // back-to-back: each call starts in the done cycle of the previous one
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        run_op(corners[i], corners[j], 1'b0, "R7 R8 corner pair back to back");

    for (int i = 0; i < 200; i++)
      run_op($urandom, $urandom, 1'b0, "R2 random operands");

    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R5 start while busy ignored");
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R5 start while busy ignored");

    run_op(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, "R2 fixed operands");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(res === 64'hDEAD_BEEF * 64'hCAFE_F00D, "R6 result held", res,
            64'hDEAD_BEEF * 64'hCAFE_F00D);
      check(done === 1'b0, "R6 done stays low", {63'b0, done}, 64'd0);
    end

    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        run_small(6'(a), 6'(b));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule